// File: doc/BRIEF.md
# Unaligned Access Exception Detector

This block watches every load/store issued by a processor pipeline and checks the access address against the access size. A halfword access must sit on an even address and a word access on a multiple of four; byte accesses are always legal. When an access breaks this rule, the block records the full faulting address and builds a status word. That word packs an exception code, the register involved, the direction and whether the access was a word or a halfword.

The recorded address and status are kept whether or not exceptions are enabled. A one-cycle exception request goes to the trap logic only when the enable bit is set. Both registers keep their contents until the next misaligned access or a reset. The memory access itself and the exception vectoring are handled elsewhere.

Size encoding on `size_i`: 2'b00 byte, 2'b01 halfword, 2'b10 word, 2'b11 treated as word.

Top module: `unalign_exc`

## Requirements
- R1: A byte access (size 2'b00) never faults, at any address. It leaves addr_reg_o and stat_reg_o unchanged and raises no request.
- R2: A halfword access (size 2'b01) faults exactly when address bit 0 is 1.
- R3: A word access (size 2'b10 or 2'b11) faults exactly when address bits 1:0 are not both 0.
- R4: On a fault, addr_reg_o holds the full faulting address from the cycle after the strobe.
- R5: On a fault, stat_reg_o bits 4:0 hold 5'b00001, bits 9:5 the register number, bit 10 the write flag and bit 11 a 1 for a word access and a 0 for a halfword access. All other bits are 0.
- R6: With exc_en_i = 1, a fault drives exc_req_o high for exactly the one cycle after the faulting strobe.
- R7: With exc_en_i = 0, a fault still updates addr_reg_o and stat_reg_o, but exc_req_o stays low.
- R8: An aligned access, or any cycle with valid_i low, leaves addr_reg_o and stat_reg_o unchanged and exc_req_o low.
- R9: After reset, addr_reg_o, stat_reg_o and exc_req_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Access strobe |
| addr_i | input | 32 | Access address |
| size_i | input | 2 | Access size code |
| write_i | input | 1 | 1 for store, 0 for load |
| reg_num_i | input | 5 | Destination or source register number |
| exc_en_i | input | 1 | Exceptions enable |
| addr_reg_o | output | 32 | Captured faulting address |
| stat_reg_o | output | 32 | Exception status word |
| exc_req_o | output | 1 | Exception request pulse |

## Verification
The bench builds the block with its default widths: a 32-bit address and status word and a 5-bit register number. With these widths the write flag lands at bit 10 and the size flag at bit 11. Addresses with high bits set show that the full address is captured, not only the low bits. Back-to-back faults, faults with exceptions disabled, and idle or aligned cycles placed between faults show the pulse width, the hold behaviour and that registers are updated without a trap.

// File: rtl/unalign_pkg.sv
package unalign_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WRD2 = 2'b11
  } acc_size_e;

  localparam logic [4:0] EC_UNALIGNED = 5'b00001;
  localparam int         EC_W         = 5;
endpackage

// File: rtl/unalign_detect.sv
module unalign_detect
  import unalign_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output logic              fault_o,
  output logic              is_word_o
);
  logic [1:0] mask;

  always_comb begin
    unique case (acc_size_e'(size_i))
      SZ_BYTE: mask = 2'b00;
      SZ_HALF: mask = 2'b01;
      default: mask = 2'b11;
    endcase
  end

  assign is_word_o = (mask == 2'b11);
  assign fault_o   = valid_i && |(addr_i[1:0] & mask);
endmodule

// File: rtl/unalign_stat_pack.sv
module unalign_stat_pack
  import unalign_pkg::*;
#(
  parameter int STAT_W = 32,
  parameter int REG_W  = 5
) (
  input  logic              write_i,
  input  logic              is_word_i,
  input  logic [REG_W-1:0]  reg_num_i,
  output logic [STAT_W-1:0] stat_o
);
  localparam int REG_LSB = EC_W;
  localparam int WR_BIT  = REG_LSB + REG_W;
  localparam int SZ_BIT  = WR_BIT + 1;

  always_comb begin
    stat_o                          = '0;
    stat_o[EC_W-1:0]                = EC_UNALIGNED;
    stat_o[REG_LSB +: REG_W]        = reg_num_i;
    stat_o[WR_BIT]                  = write_i;
    stat_o[SZ_BIT]                  = is_word_i;
  end
endmodule

// File: rtl/unalign_exc.sv
module unalign_exc
  import unalign_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STAT_W = 32,
  parameter int REG_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              write_i,
  input  logic [REG_W-1:0]  reg_num_i,
  input  logic              exc_en_i,
  output logic [ADDR_W-1:0] addr_reg_o,
  output logic [STAT_W-1:0] stat_reg_o,
  output logic              exc_req_o
);
  logic              fault;
  logic              is_word;
  logic [STAT_W-1:0] stat_nxt;

  unalign_detect #(.ADDR_W(ADDR_W)) u_detect (
    .valid_i   (valid_i),
    .addr_i    (addr_i),
    .size_i    (size_i),
    .fault_o   (fault),
    .is_word_o (is_word)
  );

  unalign_stat_pack #(.STAT_W(STAT_W), .REG_W(REG_W)) u_pack (
    .write_i   (write_i),
    .is_word_i (is_word),
    .reg_num_i (reg_num_i),
    .stat_o    (stat_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_reg_o <= '0;
      stat_reg_o <= '0;
      exc_req_o  <= 1'b0;
    end else begin
      exc_req_o <= fault && exc_en_i;
      if (fault) begin
        addr_reg_o <= addr_i;
        stat_reg_o <= stat_nxt;
      end
    end
  end
endmodule

// File: rtl/unalign_exc_chk.sv
module unalign_exc_chk #(
  parameter int ADDR_W = 32,
  parameter int STAT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [1:0]        size_i,
  input logic              exc_en_i,
  input logic [ADDR_W-1:0] addr_reg_o,
  input logic [STAT_W-1:0] stat_reg_o,
  input logic              exc_req_o
);
  logic live;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) live <= 1'b0;
    else         live <= 1'b1;

  // R1
  byte_no_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && valid_i && size_i == 2'b00) |=> (!exc_req_o && $stable(addr_reg_o) && $stable(stat_reg_o)));

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && !valid_i) |=> (!exc_req_o && $stable(addr_reg_o) && $stable(stat_reg_o)));

  // R7
  no_req_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !exc_en_i) |=> !exc_req_o);

  // R4
  ear_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && exc_req_o) |-> (addr_reg_o == $past(addr_i)));

  // R5
  code_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_reg_o != '0) |-> (stat_reg_o[4:0] == 5'b00001));
endmodule

bind unalign_exc unalign_exc_chk #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .addr_i     (addr_i),
  .size_i     (size_i),
  .exc_en_i   (exc_en_i),
  .addr_reg_o (addr_reg_o),
  .stat_reg_o (stat_reg_o),
  .exc_req_o  (exc_req_o)
);

// File: tb/unalign_exc_tb.sv
module unalign_exc_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [1:0]  size_i = '0;
  logic        write_i = 1'b0;
  logic [4:0]  reg_num_i = '0;
  logic        exc_en_i = 1'b0;
  logic [31:0] addr_reg_o;
  logic [31:0] stat_reg_o;
  logic        exc_req_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [31:0] ear;
    logic [31:0] esr;
    logic        req;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  logic [31:0] m_ear = '0;
  logic [31:0] m_esr = '0;

  always #2 clk_i = ~clk_i;

  unalign_exc u_dut (
    .clk_i, .rst_ni, .valid_i, .addr_i, .size_i, .write_i,
    .reg_num_i, .exc_en_i, .addr_reg_o, .stat_reg_o, .exc_req_o
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one access per cycle, expected state after the next edge queued
  task automatic drive(string tag, bit v, logic [31:0] a, logic [1:0] sz,
                       bit wr, logic [4:0] rn, bit en);
    bit   flt;
    exp_t e;
    @(negedge clk_i);
    valid_i = v; addr_i = a; size_i = sz; write_i = wr; reg_num_i = rn; exc_en_i = en;
    case (sz)
      2'b00:   flt = 1'b0;                  // R1
      2'b01:   flt = v && a[0];             // R2
      default: flt = v && (a[1:0] != 0);    // R3
    endcase
    if (flt) begin
      m_ear = a;                            // R4
      m_esr = {20'h0, sz != 2'b01, wr, rn, 5'b00001}; // R5
    end
    e.ear = m_ear; e.esr = m_esr; e.req = flt && en; e.tag = tag; // R6 R7 R8
    sb_q.push_back(e);
  endtask

  // monitor
  always @(posedge clk_i) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check({e.tag, " ear"}, addr_reg_o, e.ear);
      check({e.tag, " esr"}, stat_reg_o, e.esr);
      check({e.tag, " req"}, {31'h0, exc_req_o}, {31'h0, e.req});
    end
  end

  initial begin
    #3000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    check("R9 ear reset", addr_reg_o, 32'h0);
    check("R9 esr reset", stat_reg_o, 32'h0);
    check("R9 req reset", {31'h0, exc_req_o}, 32'h0);
    @(negedge clk_i) rst_ni = 1'b1;

    drive("R1 byte odd",      1, 32'hFFFF_FFF3, 2'b00, 1, 5'd7,  1);
    drive("R2 half aligned",  1, 32'h0000_1002, 2'b01, 0, 5'd3,  1);
    drive("R2 half odd",      1, 32'h8000_1001, 2'b01, 0, 5'd9,  1);
    drive("R6 pulse ends",    0, 32'h0000_0003, 2'b10, 0, 5'd0,  1);
    drive("R3 word off2",     1, 32'hDEAD_BEE2, 2'b10, 1, 5'd31, 1);
    drive("R3 word off1 b2b", 1, 32'h1234_5671, 2'b11, 0, 5'd16, 1);
    drive("R8 word aligned",  1, 32'h1234_5670, 2'b10, 1, 5'd1,  1);
    drive("R7 disabled fault",1, 32'hCAFE_0003, 2'b10, 1, 5'd21, 0);
    drive("R8 idle hold",     0, 32'h0000_0001, 2'b01, 1, 5'd5,  1);
    drive("R1 byte hold",     1, 32'h0000_0001, 2'b00, 0, 5'd2,  1);
    drive("R7 half disabled", 1, 32'h0000_0005, 2'b01, 0, 5'd10, 0);
    drive("R3 word off3",     1, 32'h7FFF_FFFF, 2'b10, 0, 5'd0,  1);
    for (int i = 0; i < 16; i++)
      drive("R2 R3 sweep", 1, 32'h4000_0000 + i, 2'(i % 3), i[0], 5'(i * 3), i[1]);
    drive("R8 final idle",    0, 32'h0, 2'b00, 0, 5'd0, 0);
    repeat (3) @(posedge clk_i);
    #2;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule